// File: doc/BRIEF.md
# Chip Erase Sequence Controller

This controller sits on the programming side of a byte-wide, electrically erasable, reprogrammable memory and runs the whole-array erase procedure. When a start request arrives it first writes zero into every location. Every cell therefore begins the erase from the same charged state. It then applies an erase pulse of fixed length, waits out a recovery interval, and reads the whole array back to check that every byte holds all ones. A failed check leads to another pulse. This repeats until a check passes or the pulse budget is used up.

A host raises `start` for one cycle and watches `busy`. When the run ends, exactly one of `pass` or `fail` comes up and stays up until the next start. The memory side is a single port carrying an address, write data, read data and three strobes: program, erase (the high-voltage select condition) and verify. All durations are counted in pulses of an external timebase tick. The array size, the pulse and recovery lengths and the pulse budget are all parameters.

Top module: `erase_seq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `pass`, `fail` and all three memory strobes are low.
- R2: A `start` seen while `busy` is low makes `busy` high and `pass` and `fail` low on the next cycle. A `start` seen while `busy` is high has no effect: the running sequence does not restart.
- R3: Every run begins with a program sweep. `mem_prog_en` is high for exactly DEPTH cycles, presenting addresses 0 to DEPTH-1 in ascending order, one per cycle, with `mem_wdata` = 00h. No erase strobe appears before this sweep has covered the whole array.
- R4: Each erase pulse holds `mem_erase_en` high, with the program and verify strobes low, for exactly ERASE_TICKS timebase ticks. The count starts with the first tick sampled after the strobe rises.
- R5: Between the end of an erase pulse and the next rise of `mem_verify_en`, at least RECOV_TICKS ticks pass with all strobes low.
- R6: A verify sweep holds `mem_verify_en` high and presents addresses in ascending order from 0, one per cycle. If every byte reads all ones (FFh), `pass` is raised.
- R7: A verify sweep stops on the cycle where the byte read is not FFh. That byte's address is the last one presented. Unless the budget is used up, `mem_erase_en` rises on the very next cycle.
- R8: At most MAX_RETRY erase pulses are applied per run. If the verify after pulse number MAX_RETRY fails, `fail` is raised and no further pulse follows.
- R9: `pass` and `fail` are never high together, and never while `busy` is high. Whichever was raised stays high, with `busy` low, until the next accepted `start`.
- R10: At most one of `mem_prog_en`, `mem_erase_en` and `mem_verify_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an erase run |
| tick | input | 1 | Timebase pulse; durations are counted in these |
| busy | output | 1 | A run is in progress |
| pass | output | 1 | Last run ended with the array verified erased |
| fail | output | 1 | Last run used up its pulse budget without a clean verify |
| mem_addr | output | AW | Memory address (AW = clog2(DEPTH)) |
| mem_wdata | output | DW | Data written during the program sweep |
| mem_rdata | input | DW | Read data, valid in the same cycle as `mem_addr` |
| mem_erase_en | output | 1 | Erase strobe (high-voltage select, program off) |
| mem_prog_en | output | 1 | Program strobe; the memory writes `mem_wdata` at the clock edge |
| mem_verify_en | output | 1 | Verify-read strobe |

## Verification
Several properties are checked on every cycle: the strobes never overlap, pass and fail never overlap each other or busy, and an outcome flag holds until a new start. Also checked every cycle: an erase pulse begins only right after a program or verify sweep, verify never directly follows erase, the tick timer stays below its limit, and the retry counter is never bumped at its limit. The exact pulse length in ticks, the recovery length, the all-zero state of the array before the first pulse, and the early stop of verify at a partly erased byte can only be shown by the bench. The same goes for the total number of pulses against a memory model that needs a chosen number of pulses to clear.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_RECOV,
        ST_VERIFY,
        ST_PASSED,
        ST_FAILED
    } seq_state_e;

    typedef struct packed {
        logic erase;
        logic prog;
        logic verify;
    } mem_strobe_t;

    function automatic mem_strobe_t strobe_of(seq_state_e s);
        mem_strobe_t r;
        r.erase  = (s == ST_ERASE);
        r.prog   = (s == ST_PROG);
        r.verify = (s == ST_VERIFY);
        return r;
    endfunction

    function automatic logic is_active(seq_state_e s);
        return (s == ST_PROG) || (s == ST_ERASE) ||
               (s == ST_RECOV) || (s == ST_VERIFY);
    endfunction

    function automatic logic is_done(seq_state_e s);
        return (s == ST_IDLE) || (s == ST_PASSED) || (s == ST_FAILED);
    endfunction

endpackage

// File: rtl/sweep_counter.sv
module sweep_counter #(
    parameter int DEPTH = 131072,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_last
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (step)
            addr <= addr + 1'b1;
    end

    assign at_last = (addr == LAST);

    // R3
    sweep_range_chk: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST);

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign done = tick && (cnt == limit - 1'b1);

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/retry_counter.sv
module retry_counter #(
    parameter int MAX_RETRY = 200,
    parameter int RW        = $clog2(MAX_RETRY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic at_limit
);
    localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY - 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (bump)
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LIMIT);

    // R8
    retry_cap_chk: assert property (@(posedge clk) disable iff (rst)
        bump |-> !at_limit);

    // R8
    retry_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
    import erase_seq_pkg::*;
#(
    parameter int DEPTH       = 131072,
    parameter int DW          = 8,
    parameter int ERASE_TICKS = 500,
    parameter int RECOV_TICKS = 500,
    parameter int MAX_RETRY   = 200,
    parameter int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tick,
    output logic          busy,
    output logic          pass,
    output logic          fail,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_erase_en,
    output logic          mem_prog_en,
    output logic          mem_verify_en
);
    localparam int TMAX = (ERASE_TICKS > RECOV_TICKS) ? ERASE_TICKS : RECOV_TICKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [DW-1:0] ERASED = {DW{1'b1}};

    seq_state_e  state_q, state_d;
    mem_strobe_t strb;

    logic          addr_last, addr_step, phase_change;
    logic          tmr_done, tmr_tick;
    logic [TW-1:0] tmr_limit;
    logic          retry_last, retry_bump, retry_clr;
    logic          byte_ok;

    assign byte_ok = (mem_rdata == ERASED);

    always_comb begin
        state_d    = state_q;
        retry_bump = 1'b0;
        retry_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PASSED, ST_FAILED: begin
                if (start) begin
                    state_d   = ST_PROG;
                    retry_clr = 1'b1;
                end
            end
            ST_PROG: begin
                if (addr_last)
                    state_d = ST_ERASE;
            end
            ST_ERASE: begin
                if (tmr_done)
                    state_d = ST_RECOV;
            end
            ST_RECOV: begin
                if (tmr_done)
                    state_d = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (!byte_ok) begin
                    if (retry_last) begin
                        state_d = ST_FAILED;
                    end else begin
                        state_d    = ST_ERASE;
                        retry_bump = 1'b1;
                    end
                end else if (addr_last) begin
                    state_d = ST_PASSED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign phase_change = (state_d != state_q);
    assign addr_step    = (strb.prog || strb.verify) && !phase_change;
    assign tmr_tick     = tick && ((state_q == ST_ERASE) || (state_q == ST_RECOV));
    assign tmr_limit    = (state_q == ST_ERASE) ? TW'(ERASE_TICKS) : TW'(RECOV_TICKS);

    sweep_counter #(.DEPTH(DEPTH), .AW(AW)) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase_change),
        .step    (addr_step),
        .addr    (mem_addr),
        .at_last (addr_last)
    );

    tick_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (phase_change),
        .tick  (tmr_tick),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    retry_counter #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk      (clk),
        .rst      (rst),
        .clr      (retry_clr),
        .bump     (retry_bump),
        .at_limit (retry_last)
    );

    assign strb          = strobe_of(state_q);
    assign mem_erase_en  = strb.erase;
    assign mem_prog_en   = strb.prog;
    assign mem_verify_en = strb.verify;
    assign mem_wdata     = '0;
    assign busy          = is_active(state_q);
    assign pass          = (state_q == ST_PASSED);
    assign fail          = (state_q == ST_FAILED);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_erase_en, mem_prog_en, mem_verify_en}));

    // R9
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({busy, pass, fail}) <= 1);

    // R9
    pass_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pass |=> (pass || busy));

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fail |=> (fail || busy));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7
    erase_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_erase_en) |-> ($past(mem_prog_en) || $past(mem_verify_en)));

    // R5
    recov_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_verify_en) |-> !$past(mem_erase_en));

endmodule

// File: tb/sim_erase_seq_ctrl.sv
module sim_erase_seq_ctrl;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int ET    = 4;
    localparam int RT    = 3;
    localparam int MR    = 3;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tick = 1'b0;
    logic busy, pass, fail;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic mem_erase_en, mem_prog_en, mem_verify_en;

    logic [DW-1:0] mem [DEPTH];

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int need = 1;
    int run_id = 0;
    int seen_id = 0;
    int pulses, prog_cnt, vcyc, exp_vcyc, vidx, er_ticks, rc_ticks;
    bit pe, pv, in_gap;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    erase_seq_ctrl #(
        .DEPTH(DEPTH), .DW(DW), .ERASE_TICKS(ET), .RECOV_TICKS(RT), .MAX_RETRY(MR)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .tick(tick),
        .busy(busy), .pass(pass), .fail(fail),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_erase_en(mem_erase_en), .mem_prog_en(mem_prog_en),
        .mem_verify_en(mem_verify_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit all_zero();
        for (int i = 0; i < DEPTH; i++)
            if (mem[i] != 8'h00) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_pulses(input int n);
        return (n < MR) ? n : MR;
    endfunction

    // memory model, tick source and sweep monitor
    always @(negedge clk) begin
        cyc++;
        tick = (($urandom % 3) == 0);
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (run_id != seen_id) begin
            seen_id = run_id;
            for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
            pulses = 0; prog_cnt = 0; vcyc = 0; exp_vcyc = 0;
            in_gap = 0; er_ticks = 0; rc_ticks = 0; vidx = 0;
        end
        if (!rst) begin
            // R10
            check($countones({mem_erase_en, mem_prog_en, mem_verify_en}) <= 1,
                  "R10", "strobe overlap",
                  $countones({mem_erase_en, mem_prog_en, mem_verify_en}), 1);
            if (mem_prog_en) begin
                // R3
                check(int'(mem_addr) == prog_cnt, "R3", "program address", mem_addr, prog_cnt);
                check(mem_wdata == 8'h00, "R3", "program data", mem_wdata, 0);
                mem[mem_addr] = mem_wdata;
                prog_cnt++;
            end
            if (mem_erase_en && !pe) begin
                pulses++;
                if (pulses == 1) begin
                    check(prog_cnt == DEPTH, "R3", "bytes programmed before erase", prog_cnt, DEPTH);
                    check(all_zero(), "R3", "array zero before erase", 0, 1);
                end else begin
                    check(pv, "R7", "erase follows verify directly", pv, 1);
                end
                er_ticks = 0;
                in_gap = 0;
            end
            if (!mem_erase_en && pe) begin
                // R4
                check(er_ticks == ET, "R4", "erase pulse ticks", er_ticks, ET);
                if (pulses >= need) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
                    exp_vcyc += DEPTH;
                end else begin
                    int b;
                    b = $urandom % DEPTH;
                    for (int i = 0; i < b; i++) mem[i] = 8'hFF;
                    mem[b] = 8'h5A;
                    exp_vcyc += b + 1;
                end
                in_gap = 1;
                rc_ticks = 0;
            end
            if (mem_erase_en && tick) er_ticks++;
            if (in_gap && !mem_verify_en && !mem_erase_en && tick) rc_ticks++;
            if (mem_verify_en && !pv) begin
                // R5
                check(rc_ticks >= RT, "R5", "recovery ticks", rc_ticks, RT);
                in_gap = 0;
                vidx = 0;
            end
            if (mem_verify_en) begin
                // R6
                check(int'(mem_addr) == vidx, "R6", "verify address", mem_addr, vidx);
                vidx++;
                vcyc++;
            end
        end
        pe = mem_erase_en;
        pv = mem_verify_en;
    end

    task automatic run(input int n);
        bit exp_pass;
        int waitc;
        exp_pass = (n <= MR);
        need = n;
        run_id++;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2
        check(busy && !pass && !fail, "R2", "start accepted", {busy, pass, fail}, 3'b100);
        repeat (3) @(negedge clk);
        start = 1'b1;       // ignored: already busy
        @(negedge clk);
        start = 1'b0;
        waitc = 0;
        while (!(pass || fail) && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        @(negedge clk);
        check(prog_cnt == DEPTH, "R2", "no restart on busy start", prog_cnt, DEPTH);
        check(pass == exp_pass, "R6", "pass flag", pass, exp_pass);
        check(fail == !exp_pass, "R8", "fail flag", fail, !exp_pass);
        check(pulses == exp_pulses(n), "R8", "erase pulse count", pulses, exp_pulses(n));
        check(vcyc == exp_vcyc, "R7", "verify cycles with early stop", vcyc, exp_vcyc);
        repeat (4) @(negedge clk);
        check(!busy && (pass == exp_pass) && (fail == !exp_pass), "R9",
              "outcome latched", {busy, pass, fail}, {1'b0, exp_pass, !exp_pass});
        check(!(pass && fail), "R9", "outcome exclusive", {pass, fail}, 1);
    endtask

    initial begin
        int s;
        s = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        // R1
        check(!busy && !pass && !fail, "R1", "flags in reset", {busy, pass, fail}, 0);
        check(!mem_erase_en && !mem_prog_en && !mem_verify_en, "R1", "strobes in reset",
              {mem_erase_en, mem_prog_en, mem_verify_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !pass && !fail, "R1", "flags after reset", {busy, pass, fail}, 0);
        run(1);
        run(2);
        run(MR);
        run(MR + 1);
        run(1);
        run(99);
        run(2);
        for (int k = 0; k < 6; k++) run(1 + ($urandom % (MR + 1)));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule